// File: doc/BRIEF.md
# Handshake-Gated Serial Transmitter

This block serializes bytes onto a single transmit line in 8N1 framing: one low start bit, eight data bits least significant first, and one high stop bit. Bit timing comes from an external baud tick. Each bit lasts a fixed number of ticks, set by a parameter. A one-entry holding register takes bytes from the host side and passes each one to the shift register as soon as the shifter is free.

The transmitter can also be gated by an active-low clear-to-send pin. The gate is active only when both the automatic handshake enable and the FIFO-mode enable are set and the synchronized pin reads high (deasserted). While the gate is active, the shifter freezes in place, including in the middle of a bit. The line holds its current level and the tick counter keeps its count. When the gate lifts, the frame continues from exactly that point. The holding register keeps its byte for the whole pause.

The pin passes through a two-flop synchronizer before it is used. This makes a change on the pin take effect two clocks later.

Top module: `cts_uart_tx`

## Requirements
- R1: Out of reset, txd_o is high and thr_empty_o is high.
- R2: A frame drives txd_o low for the start bit, then the eight data bits with bit 0 first, then high for the stop bit. Each bit lasts TICKS_PER_BIT (default 4) baud ticks, and the line is high whenever no frame is in progress.
- R3: thr_empty_o goes low on the clock edge that captures a write. It returns high on the edge where the byte moves into the shifter. That edge is the next one when the shifter is idle and the gate is inactive, and the start bit appears on txd_o at that same edge.
- R4: A write while the holding register is full replaces the held byte. A write on the very edge of a transfer leaves the old byte in the shifter and the new byte held.
- R5: The gate is active when auto_cts_en_i and fifo_en_i are both 1 and cts_ni has been high for two clocks. A change on cts_ni is seen only after two clock edges.
- R6: When the gate becomes active mid-frame, txd_o keeps the level of the current bit and ticks are not counted. After release, the bit ends once its remaining ticks arrive, and the frame continues with the next bit.
- R7: While the gate is active and the shifter is idle, no byte leaves the holding register: thr_empty_o stays low and txd_o stays high.
- R8: With auto_cts_en_i at 0, cts_ni has no effect on transmission.
- R9: With fifo_en_i at 0, auto_cts_en_i is ignored and cts_ni has no effect.
- R10: A byte held during a frame starts one clock after that frame's stop bit ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse per baud subdivision |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to transmit |
| auto_cts_en_i | input | 1 | Enables automatic clear-to-send gating |
| fifo_en_i | input | 1 | FIFO mode; gating is possible only when set |
| cts_ni | input | 1 | Clear-to-send pin, active low, asynchronous |
| txd_o | output | 1 | Serial transmit line |
| thr_empty_o | output | 1 | Holding register empty |

## Verification
A host write can land on the same edge where the previous byte leaves the holding register for the shifter. The bench provokes this by asserting a second write in the cycle right after the first one is captured, while the shifter is idle. It then checks three things: the start bit appears, thr_empty_o stays low, and the two frames come out in write order. A pause can also overlap a write into the holding register. This is provoked by writing during a mid-frame stall, and judged by the exact bit and tick at which the frame resumes and by the content of the following frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam logic IDLE_LVL  = 1'b1;
  localparam logic START_LVL = 1'b0;
  localparam logic STOP_LVL  = 1'b1;

  function automatic int frame_len(input int data_w);
    return data_w + 2;
  endfunction
endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RESET_VAL}};
    else         q <= {q[STAGES-2:0], async_i};
  end

  assign sync_o = q[STAGES-1];
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      // write wins over a simultaneous take: shifter gets old byte
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FRAME_W = frame_len(DATA_W);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int TCNT_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [IDX_W-1:0]  LAST_BIT  = IDX_W'(FRAME_W - 1);
  localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(TICKS_PER_BIT - 1);

  logic [FRAME_W-1:0] sr;
  logic [IDX_W-1:0]   bit_idx;
  logic [TCNT_W-1:0]  tcnt;
  logic               advance;

  assign advance = busy_o && tick_i && !gate_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr      <= {FRAME_W{IDLE_LVL}};
      bit_idx <= '0;
      tcnt    <= '0;
      busy_o  <= 1'b0;
    end else if (load_i) begin
      sr      <= {STOP_LVL, data_i, START_LVL};
      bit_idx <= '0;
      tcnt    <= '0;
      busy_o  <= 1'b1;
    end else if (advance) begin
      if (tcnt == LAST_TICK) begin
        tcnt <= '0;
        sr   <= {IDLE_LVL, sr[FRAME_W-1:1]};
        if (bit_idx == LAST_BIT) busy_o <= 1'b0;
        else                     bit_idx <= bit_idx + 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign txd_o = busy_o ? sr[0] : IDLE_LVL;
endmodule

// File: rtl/cts_uart_tx.sv
module cts_uart_tx #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              auto_cts_en_i,
  input  logic              fifo_en_i,
  input  logic              cts_ni,
  output logic              txd_o,
  output logic              thr_empty_o
);
  logic              cts_n_s;
  logic              tx_gate;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              shift_busy;
  logic              load;

  cts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cts_ni),
    .sync_o  (cts_n_s)
  );

  // auto gate only exists in FIFO mode
  assign tx_gate = auto_cts_en_i && fifo_en_i && cts_n_s;
  assign load    = hold_full && !shift_busy && !tx_gate;

  tx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (load),
    .full_o    (hold_full),
    .data_o    (hold_data)
  );

  tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (baud_tick_i),
    .gate_i (tx_gate),
    .load_i (load),
    .data_i (hold_data),
    .busy_o (shift_busy),
    .txd_o  (txd_o)
  );

  assign thr_empty_o = !hold_full;
endmodule

// File: rtl/cts_uart_tx_chk.sv
module cts_uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic txd_o,
  input logic thr_empty_o,
  input logic busy_i,
  input logic gate_i
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_o); // R2
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !txd_o); // R2
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !$past(wr_i)) |-> thr_empty_o); // R3
  AST_WR_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !thr_empty_o); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && gate_i) |=> (busy_i && $stable(txd_o))); // R6
  AST_GATED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && gate_i) |=> !busy_i); // R7
endmodule

bind cts_uart_tx cts_uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .txd_o       (txd_o),
  .thr_empty_o (thr_empty_o),
  .busy_i      (shift_busy),
  .gate_i      (tx_gate)
);

// File: tb/cts_uart_tx_test.sv
`timescale 1ns/1ps
module cts_uart_tx_test;
  localparam int TPB = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       auto_cts_en_i = 1'b0;
  logic       fifo_en_i = 1'b0;
  logic       cts_ni = 1'b0;
  logic       txd_o;
  logic       thr_empty_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cts_uart_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .auto_cts_en_i(auto_cts_en_i), .fifo_en_i(fifo_en_i),
    .cts_ni(cts_ni), .txd_o(txd_o), .thr_empty_o(thr_empty_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks enter and leave at a negedge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      baud_tick_i = 1'b1;
      @(negedge clk);
      baud_tick_i = 1'b0;
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  function automatic logic bit_lvl(input logic [7:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return d[b-1];
  endfunction

  // checks bits from 'first' to stop, start bit already on the line
  task automatic check_bits(input string req, input logic [7:0] d, input int first);
    for (int b = first; b < 10; b++) begin
      chk(req, txd_o, bit_lvl(d, b));
      tick(TPB);
    end
    chk({req, " idle after stop"}, txd_o, 1'b1);
  endtask

  task automatic test_reset;
    chk("R1 txd", txd_o, 1'b1);
    chk("R1 thr_empty", thr_empty_o, 1'b1);
  endtask

  task automatic test_basic;
    do_write(8'hA5);
    chk("R3 full after write", thr_empty_o, 1'b0);
    @(negedge clk);
    chk("R3 empty after move", thr_empty_o, 1'b1);
    check_bits("R2 frame A5", 8'hA5, 0);
    do_write(8'h01);
    @(negedge clk);
    check_bits("R2 frame 01", 8'h01, 0);
  endtask

  task automatic test_same_cycle;
    do_write(8'h6C);
    do_write(8'h11);         // lands on transfer edge of 6C
    chk("R4 start on transfer", txd_o, 1'b0);
    chk("R4 new byte held", thr_empty_o, 1'b0);
    tick(TPB * 3);
    do_write(8'hE2);         // replaces 11
    check_bits("R4 first frame", 8'h6C, 3);
    @(negedge clk);
    chk("R10 next start", txd_o, 1'b0);
    check_bits("R4 overwrite frame", 8'hE2, 0);
    chk("R10 drained", thr_empty_o, 1'b1);
  endtask

  task automatic test_pause;
    auto_cts_en_i = 1'b1; fifo_en_i = 1'b1; cts_ni = 1'b0;
    repeat (3) @(negedge clk);
    do_write(8'hA5);
    @(negedge clk);
    tick(TPB * 3 + 2);       // into bit 3 (data bit 2 = 1)
    cts_ni = 1'b1;
    repeat (3) @(negedge clk);
    tick(6);
    chk("R6 level held", txd_o, 1'b1);
    do_write(8'h3C);
    chk("R6 held byte kept", thr_empty_o, 1'b0);
    tick(3);
    chk("R6 still held", txd_o, 1'b1);
    cts_ni = 1'b0;
    repeat (3) @(negedge clk);
    tick(1);
    chk("R6 tick count kept", txd_o, 1'b1);
    tick(1);
    chk("R6 resume next bit", txd_o, 1'b0);
    check_bits("R6 rest of frame", 8'hA5, 4);
    @(negedge clk);
    check_bits("R6 frame after pause", 8'h3C, 0);
  endtask

  task automatic test_gated_idle;
    auto_cts_en_i = 1'b1; fifo_en_i = 1'b1; cts_ni = 1'b1;
    repeat (3) @(negedge clk);
    do_write(8'h5A);
    tick(5);
    chk("R7 byte stays held", thr_empty_o, 1'b0);
    chk("R7 line idle", txd_o, 1'b1);
    cts_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 sync delay", txd_o, 1'b1);
    @(negedge clk);
    chk("R5 start after sync", txd_o, 1'b0);
    chk("R5 moved", thr_empty_o, 1'b1);
    check_bits("R5 frame", 8'h5A, 0);
  endtask

  task automatic test_auto_off;
    auto_cts_en_i = 1'b0; fifo_en_i = 1'b1; cts_ni = 1'b1;
    repeat (3) @(negedge clk);
    do_write(8'hC3);
    @(negedge clk);
    chk("R8 starts", txd_o, 1'b0);
    check_bits("R8 frame", 8'hC3, 0);
  endtask

  task automatic test_fifo_off;
    auto_cts_en_i = 1'b1; fifo_en_i = 1'b0; cts_ni = 1'b1;
    repeat (3) @(negedge clk);
    do_write(8'h96);
    @(negedge clk);
    chk("R9 starts", txd_o, 1'b0);
    tick(TPB * 2);
    chk("R9 advances", txd_o, 1'b1);
    check_bits("R9 frame", 8'h96, 2);
    cts_ni = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    test_reset;
    test_basic;
    test_same_cycle;
    test_pause;
    test_gated_idle;
    test_auto_off;
    test_fifo_off;
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule